// File: doc/BRIEF.md
# Two-Channel Measurement Register Target over SPI

This block is the device side of a serial register port for a front end that measures one current and one voltage. A host selects the block with an active-low chip select and sends a 16-bit command: a direction bit, then fifteen address bits. The data bytes follow. The block holds configuration, identification, status and result registers, all eight bits wide. On every data byte of a burst, reads and writes alike, the register pointer counts down by one.

The result registers hold two 12-bit unsigned codes. Their values come from a sample-source input. A new pair is copied in only when one chip-select frame has read all four result bytes in descending order, high current byte first and low voltage byte last, so the host never sees half of an old pair joined to half of a new one. A write to the control register can request a soft reset. This reset clears the volatile registers and restarts the readiness delay, but leaves both configuration registers unchanged. The SPI pins are oversampled in the system clock domain.

Top module: `spi_meas_target`

## Requirements
- R1: After reset, address 0x0000 reads 0x99; addresses 0x0001, 0x000F and 0x0100 read 0x00; all four result bytes read 0x00.
- R2: The bus uses SPI mode 0 with the most significant bit first. A frame starts with command bit 15, where 1 means read and 0 means write, followed by address bits 14..0; the upper address bit is taken as zero. In a read, each data byte returns the addressed register.
- R3: After each data byte in a frame the pointer decrements by one, for both reads and writes.
- R4: Only 0x0000, 0x0001, 0x000F and 0x0100 store written bytes. A write to any other address changes nothing that can be read back.
- R5: 0x0006 reads the revision constant (default 0x01), 0x000C reads 0x51 and 0x000D reads 0x04. Every address outside the readable set reads 0x00, and so do 0x0002 to 0x0005.
- R6: Address 0x0103 reads 0x00 for READY_CYC clock cycles after reset, and 0x01 from then on.
- R7: The voltage code sits at 0x0200 (bits 7..0) and 0x0201 (bits 11..8 in bits 3..0, upper bits zero). The current code sits at 0x0202 and 0x0203 with the same layout.
- R8: The sample inputs are copied into the result registers only when the byte at 0x0200 completes and the same frame has already read 0x0203, 0x0202 and 0x0201 in that order. The new pair is visible from the next frame on.
- R9: A frame that ends before the 0x0200 byte completes, or one that never read 0x0203, leaves the result registers unchanged.
- R10: Writing 0x0100 with bit 0 set clears 0x000F, 0x0100 and the result registers and restarts the R6 delay, while 0x0000 and 0x0001 keep their values.
- R11: The data output is driven low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low, frames one transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, registered |
| smp_volt | input | SMP_W | Voltage code from the sample source |
| smp_curr | input | SMP_W | Current code from the sample source |

## Verification
The assertions assume that the host holds chip select low across a whole frame and that each serial clock phase lasts several system clocks. This ensures every edge is detected once and the prefetched byte is loaded before the next falling edge. The bench drives each phase for eight system clocks and leaves a gap of at least that length between frames. It changes the sample inputs only between frames. It also never ends a frame in the same system cycle as its last rising edge, so a burst that reads down to 0x0200 always completes inside the frame.

// File: rtl/spi_meas_pkg.sv
package spi_meas_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam addr_t A_CFG0   = 16'h0000;
  localparam addr_t A_CFG1   = 16'h0001;
  localparam addr_t A_REV    = 16'h0006;
  localparam addr_t A_ID_LO  = 16'h000C;
  localparam addr_t A_ID_HI  = 16'h000D;
  localparam addr_t A_COMMIT = 16'h000F;
  localparam addr_t A_CTRL   = 16'h0100;
  localparam addr_t A_STAT   = 16'h0103;
  localparam addr_t A_V_LO   = 16'h0200;
  localparam addr_t A_V_HI   = 16'h0201;
  localparam addr_t A_I_LO   = 16'h0202;
  localparam addr_t A_I_HI   = 16'h0203;

  localparam byte_t CFG0_RST = 8'h99;

  // progress of a descending read through the four result bytes
  typedef enum logic [1:0] {TRK_NONE, TRK_HAVE3, TRK_HAVE2, TRK_HAVE1} trk_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel,
  output logic mosi_s
);
  logic [SYNC:0]   sclk_p;
  logic [SYNC-1:0] cs_p;
  logic [SYNC-1:0] mosi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
    end
  end

  assign sclk_rise = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign sclk_fall = ~sclk_p[SYNC-1] & sclk_p[SYNC];
  assign sel       = ~cs_p[SYNC-1];
  assign mosi_s    = mosi_p[SYNC-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_meas_pkg::*;
#(
  parameter int CMD_W = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             rise,
  input  logic             fall,
  input  logic             mosi_s,
  input  logic             ld_en,
  input  byte_t            ld_byte,
  output logic             cmd_stb,
  output logic [CMD_W-1:0] cmd_word,
  output logic             byte_stb,
  output byte_t            byte_word,
  output logic             miso
);
  localparam int CNT_W = $clog2(CMD_W);

  logic             in_cmd;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] rx;
  byte_t            tx;
  logic [CMD_W-1:0] rx_nxt;

  assign rx_nxt = {rx[CMD_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      in_cmd    <= 1'b1;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      cmd_stb   <= 1'b0;
      byte_stb  <= 1'b0;
      miso      <= 1'b0;
      if (rst) begin
        cmd_word  <= '0;
        byte_word <= '0;
      end
    end else begin
      cmd_stb  <= 1'b0;
      byte_stb <= 1'b0;
      if (rise) begin
        rx <= rx_nxt;
        if (in_cmd && cnt == CNT_W'(CMD_W-1)) begin
          cmd_stb  <= 1'b1;
          cmd_word <= rx_nxt;
          in_cmd   <= 1'b0;
          cnt      <= '0;
        end else if (!in_cmd && cnt == CNT_W'(BYTE_W-1)) begin
          byte_stb  <= 1'b1;
          byte_word <= rx_nxt[BYTE_W-1:0];
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (ld_en) begin
        tx <= ld_byte;
      end else if (fall && !in_cmd) begin
        miso <= tx[BYTE_W-1];
        tx   <= {tx[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_meas_regs.sv
module spi_meas_regs
  import spi_meas_pkg::*;
#(
  parameter int    SMP_W     = 12,
  parameter int    READY_CYC = 256,
  parameter byte_t CHIP_REV  = 8'h01,
  parameter byte_t ID_LO     = 8'h51,
  parameter byte_t ID_HI     = 8'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             cmd_stb,
  input  addr_t            cmd_word,
  input  logic             byte_stb,
  input  byte_t            byte_word,
  input  logic [SMP_W-1:0] src_v,
  input  logic [SMP_W-1:0] src_i,
  output logic             ld_en,
  output byte_t            ld_byte,
  output logic             smp_take,
  output logic             sw_rst,
  output logic             status_ok,
  output logic [SMP_W-1:0] volt_q,
  output logic [SMP_W-1:0] curr_q,
  output byte_t            cfg_a,
  output byte_t            cfg_b
);
  localparam int RDY_W = $clog2(READY_CYC + 1);

  logic             is_rd;
  addr_t            ptr;
  addr_t            nxt_addr;
  byte_t            rd_val;
  byte_t            commit_q;
  byte_t            ctrl_q;
  logic             wr_hit;
  logic [RDY_W-1:0] rdy_cnt;
  trk_e             trk;

  assign wr_hit    = byte_stb && !is_rd;
  assign sw_rst    = wr_hit && ptr == A_CTRL && byte_word[0];
  assign smp_take  = byte_stb && is_rd && ptr == A_V_LO && trk == TRK_HAVE1;
  assign status_ok = (rdy_cnt == RDY_W'(READY_CYC));
  assign nxt_addr  = cmd_stb ? {1'b0, cmd_word[ADDR_W-2:0]} : ptr - 1'b1;

  always_comb begin
    case (nxt_addr)
      A_CFG0:   rd_val = cfg_a;
      A_CFG1:   rd_val = cfg_b;
      A_REV:    rd_val = CHIP_REV;
      A_ID_LO:  rd_val = ID_LO;
      A_ID_HI:  rd_val = ID_HI;
      A_COMMIT: rd_val = commit_q;
      A_CTRL:   rd_val = ctrl_q;
      A_STAT:   rd_val = {{(BYTE_W-1){1'b0}}, status_ok};
      A_V_LO:   rd_val = byte_t'(volt_q);
      A_V_HI:   rd_val = byte_t'(volt_q >> BYTE_W);
      A_I_LO:   rd_val = byte_t'(curr_q);
      A_I_HI:   rd_val = byte_t'(curr_q >> BYTE_W);
      default:  rd_val = '0;
    endcase
  end

  // command decode, pointer and prefetch of the next outgoing byte
  always_ff @(posedge clk) begin
    if (rst) begin
      is_rd   <= 1'b0;
      ptr     <= '0;
      ld_en   <= 1'b0;
      ld_byte <= '0;
    end else begin
      ld_en   <= cmd_stb || byte_stb;
      ld_byte <= rd_val;
      if (cmd_stb) begin
        is_rd <= cmd_word[ADDR_W-1];
        ptr   <= nxt_addr;
      end else if (byte_stb) begin
        ptr <= nxt_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a    <= CFG0_RST;
      cfg_b    <= '0;
      commit_q <= '0;
      ctrl_q   <= '0;
    end else if (sw_rst) begin
      commit_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_hit) begin
      case (ptr)
        A_CFG0:   cfg_a    <= byte_word;
        A_CFG1:   cfg_b    <= byte_word;
        A_COMMIT: commit_q <= byte_word;
        A_CTRL:   ctrl_q   <= byte_word;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      rdy_cnt <= '0;
    end else if (!status_ok) begin
      rdy_cnt <= rdy_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst || !sel) begin
      trk <= TRK_NONE;
    end else if (byte_stb && is_rd) begin
      case (ptr)
        A_I_HI:  trk <= TRK_HAVE3;
        A_I_LO:  trk <= (trk == TRK_HAVE3) ? TRK_HAVE2 : TRK_NONE;
        A_V_HI:  trk <= (trk == TRK_HAVE2) ? TRK_HAVE1 : TRK_NONE;
        default: trk <= TRK_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      volt_q <= '0;
      curr_q <= '0;
    end else if (smp_take) begin
      volt_q <= src_v;
      curr_q <= src_i;
    end
  end
endmodule

// File: rtl/spi_meas_target.sv
module spi_meas_target
  import spi_meas_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter int    SMP_W       = 12,
  parameter int    READY_CYC   = 256,
  parameter byte_t CHIP_REV    = 8'h01,
  parameter byte_t ID_LO       = 8'h51,
  parameter byte_t ID_HI       = 8'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic [SMP_W-1:0] smp_volt,
  input  logic [SMP_W-1:0] smp_curr
);
  logic             rise, fall, sel, mosi_s;
  logic             cmd_stb, byte_stb, ld_en;
  addr_t            cmd_word;
  byte_t            byte_word, ld_byte;
  logic             smp_take, sw_rst, status_ok;
  logic [SMP_W-1:0] volt_q, curr_q;
  byte_t            cfg_a, cfg_b;

  spi_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(rise), .sclk_fall(fall), .sel(sel), .mosi_s(mosi_s)
  );

  spi_frame_shifter #(.CMD_W(ADDR_W)) u_shift (
    .clk(clk), .rst(rst), .sel(sel), .rise(rise), .fall(fall),
    .mosi_s(mosi_s), .ld_en(ld_en), .ld_byte(ld_byte),
    .cmd_stb(cmd_stb), .cmd_word(cmd_word), .byte_stb(byte_stb),
    .byte_word(byte_word), .miso(spi_miso)
  );

  spi_meas_regs #(
    .SMP_W(SMP_W), .READY_CYC(READY_CYC), .CHIP_REV(CHIP_REV),
    .ID_LO(ID_LO), .ID_HI(ID_HI)
  ) u_regs (
    .clk(clk), .rst(rst), .sel(sel), .cmd_stb(cmd_stb), .cmd_word(cmd_word),
    .byte_stb(byte_stb), .byte_word(byte_word), .src_v(smp_volt),
    .src_i(smp_curr), .ld_en(ld_en), .ld_byte(ld_byte),
    .smp_take(smp_take), .sw_rst(sw_rst), .status_ok(status_ok),
    .volt_q(volt_q), .curr_q(curr_q), .cfg_a(cfg_a), .cfg_b(cfg_b)
  );
endmodule

// File: rtl/spi_meas_target_chk.sv
module spi_meas_target_chk #(
  parameter int SMP_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sel,
  input logic             spi_miso,
  input logic             cmd_stb,
  input logic             byte_stb,
  input logic             smp_take,
  input logic             sw_rst,
  input logic             status_ok,
  input logic [SMP_W-1:0] volt_q,
  input logic [SMP_W-1:0] curr_q,
  input logic [7:0]       cfg_a,
  input logic [7:0]       cfg_b
);
  assert_miso_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !spi_miso);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_stb && byte_stb));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!smp_take && !sw_rst) |=> ($stable(volt_q) && $stable(curr_q)));

  assert_cfg_keep_R10: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> ($stable(cfg_a) && $stable(cfg_b)));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!status_ok && volt_q == '0 && curr_q == '0));

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (status_ok && !sw_rst) |=> status_ok);
endmodule

bind spi_meas_target spi_meas_target_chk #(.SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .spi_miso(spi_miso), .cmd_stb(cmd_stb),
  .byte_stb(byte_stb), .smp_take(smp_take), .sw_rst(sw_rst),
  .status_ok(status_ok), .volt_q(volt_q), .curr_q(curr_q),
  .cfg_a(cfg_a), .cfg_b(cfg_b)
);

// File: tb/test_spi_meas_target.sv
`timescale 1ns/1ps
module test_spi_meas_target;
  localparam int HALF  = 8;
  localparam int RDY   = 3000;
  localparam int SMP_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [SMP_W-1:0] smp_volt = '0, smp_curr = '0;

  always #10 clk = ~clk;

  spi_meas_target #(.READY_CYC(RDY)) i_spi_meas_target (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .smp_volt(smp_volt), .smp_curr(smp_curr)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] rbuf [0:3];
  logic [7:0] wbuf [0:3];

  // bench model of the register contents
  logic [7:0] m_cfga = 8'h99, m_cfgb = 8'h00, m_commit = 8'h00, m_ctrl = 8'h00;
  logic [SMP_W-1:0] m_v = '0, m_i = '0;
  logic m_ready = 1'b0;

  function automatic logic [7:0] exp_map(input logic [15:0] a);
    case (a)
      16'h0000: return m_cfga;
      16'h0001: return m_cfgb;
      16'h0006: return 8'h01;
      16'h000C: return 8'h51;
      16'h000D: return 8'h04;
      16'h000F: return m_commit;
      16'h0100: return m_ctrl;
      16'h0103: return {7'd0, m_ready};
      16'h0200: return m_v[7:0];
      16'h0201: return {4'd0, m_v[11:8]};
      16'h0202: return m_i[7:0];
      16'h0203: return {4'd0, m_i[11:8]};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer_byte(input logic [7:0] tb, output logic [7:0] rb);
    for (int k = 7; k >= 0; k--) begin
      spi_mosi = tb[k];
      repeat (HALF) @(negedge clk);
      rb[k] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_cmd(input logic rd, input logic [15:0] a);
    logic [7:0] dummy;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer_byte({rd, a[14:8]}, dummy);
    xfer_byte(a[7:0], dummy);
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic rd_burst(input logic [15:0] a, input int n);
    frame_cmd(1'b1, a);
    for (int i = 0; i < n; i++) xfer_byte(8'h00, rbuf[i]);
    frame_end();
  endtask

  task automatic wr_burst(input logic [15:0] a, input int n);
    logic [7:0] dummy;
    frame_cmd(1'b0, a);
    for (int i = 0; i < n; i++) xfer_byte(wbuf[i], dummy);
    frame_end();
  endtask

  function automatic logic writable(input logic [15:0] a);
    return a == 16'h0000 || a == 16'h0001 || a == 16'h000F || a == 16'h0100;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h0000: m_cfga = d;
      16'h0001: m_cfgb = d;
      16'h000F: m_commit = d;
      16'h0100: m_ctrl = d;
      default: ;
    endcase
  endtask

  task automatic sweep_reads(input string tag);
    for (int a = 16'h0000; a <= 16'h0011; a++) begin
      rd_burst(16'(a), 1);
      chk(tag, {8'h00, rbuf[0]}, {8'h00, exp_map(16'(a))});
    end
    for (int a = 16'h00FE; a <= 16'h0105; a++) begin
      rd_burst(16'(a), 1);
      chk(tag, {8'h00, rbuf[0]}, {8'h00, exp_map(16'(a))});
    end
    for (int a = 16'h01FE; a <= 16'h0206; a++) begin
      rd_burst(16'(a), 1);
      chk(tag, {8'h00, rbuf[0]}, {8'h00, exp_map(16'(a))});
    end
  endtask

  task automatic full_burst_check(input string tag);
    rd_burst(16'h0203, 4);
    chk(tag, {8'h00, rbuf[0]}, {12'h000, m_i[11:8]});
    chk(tag, {8'h00, rbuf[1]}, {8'h00, m_i[7:0]});
    chk(tag, {8'h00, rbuf[2]}, {12'h000, m_v[11:8]});
    chk(tag, {8'h00, rbuf[3]}, {8'h00, m_v[7:0]});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R11: output low while deselected
    chk("R11 idle miso", {15'd0, spi_miso}, 16'h0000);

    // R6: status still zero right after reset
    rd_burst(16'h0103, 1);
    chk("R6 status early", {8'h00, rbuf[0]}, 16'h0000);

    // R1, R3: descending burst over configuration
    rd_burst(16'h0001, 2);
    chk("R1 cfg1 reset", {8'h00, rbuf[0]}, 16'h0000);
    chk("R1 cfg0 reset", {8'h00, rbuf[1]}, 16'h0099);

    // R5, R3: identification pair read high then low
    rd_burst(16'h000D, 2);
    chk("R5 id hi", {8'h00, rbuf[0]}, 16'h0004);
    chk("R3 id lo after decrement", {8'h00, rbuf[1]}, 16'h0051);

    // R6: ready after delay
    repeat (RDY) @(negedge clk);
    m_ready = 1'b1;
    rd_burst(16'h0103, 1);
    chk("R6 status ready", {8'h00, rbuf[0]}, 16'h0001);

    // R1, R2, R5, R7: map sweep after reset
    sweep_reads("R5 map sweep after reset (R1 R2 R7)");

    // R4: write every low address and non-writable ones
    for (int a = 16'h0000; a <= 16'h0010; a++) begin
      wbuf[0] = 8'hC0 | 8'(a);
      wr_burst(16'(a), 1);
      if (writable(16'(a))) model_write(16'(a), wbuf[0]);
    end
    wbuf[0] = 8'hFF; wr_burst(16'h0103, 1);
    for (int a = 16'h0200; a <= 16'h0203; a++) begin
      wbuf[0] = 8'h77; wr_burst(16'(a), 1);
    end
    wbuf[0] = 8'h6E; wr_burst(16'h0100, 1); model_write(16'h0100, 8'h6E);
    sweep_reads("R4 map sweep after writes");

    // R3: burst write steps downward
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_burst(16'h0001, 2);
    m_cfgb = 8'h11; m_cfga = 8'h22;
    rd_burst(16'h0001, 2);
    chk("R3 burst write cfg1", {8'h00, rbuf[0]}, 16'h0011);
    chk("R3 burst write cfg0", {8'h00, rbuf[1]}, 16'h0022);

    // R8, R9, R7: coherent sample gating over several patterns
    for (int k = 0; k < 5; k++) begin
      smp_volt = 12'((k * 911 + 300) % 4096);
      smp_curr = 12'(4095 - (k * 577) % 4096);
      full_burst_check("R8 full burst returns held pair (R7)");
      m_v = smp_volt; m_i = smp_curr;
      smp_volt = smp_volt ^ 12'hFFF;
      smp_curr = smp_curr + 12'd5;
      rd_burst(16'h0203, 3);
      rd_burst(16'h0202, 3);
      rd_burst(16'h0201, 2);
      full_burst_check("R9 aborted or partial bursts leave pair");
      m_v = smp_volt; m_i = smp_curr;
      rd_burst(16'h0200, 1);
      chk("R8 new low voltage visible", {8'h00, rbuf[0]}, {8'h00, m_v[7:0]});
    end

    // R10: soft reset
    wbuf[0] = 8'h3C; wr_burst(16'h000F, 1);
    wbuf[0] = 8'h01; wr_burst(16'h0100, 1);
    m_commit = 8'h00; m_ctrl = 8'h00; m_v = '0; m_i = '0; m_ready = 1'b0;
    rd_burst(16'h0103, 1);
    chk("R10 status restarted", {8'h00, rbuf[0]}, 16'h0000);
    rd_burst(16'h0001, 2);
    chk("R10 cfg1 kept", {8'h00, rbuf[0]}, 16'h0011);
    chk("R10 cfg0 kept", {8'h00, rbuf[1]}, 16'h0022);
    rd_burst(16'h000F, 1);
    chk("R10 commit cleared", {8'h00, rbuf[0]}, 16'h0000);
    rd_burst(16'h0100, 1);
    chk("R10 ctrl cleared", {8'h00, rbuf[0]}, 16'h0000);
    for (int a = 16'h0200; a <= 16'h0203; a++) begin
      rd_burst(16'(a), 1);
      chk("R10 data cleared", {8'h00, rbuf[0]}, 16'h0000);
    end
    repeat (RDY) @(negedge clk);
    m_ready = 1'b1;
    rd_burst(16'h0103, 1);
    chk("R6 status ready after soft reset", {8'h00, rbuf[0]}, 16'h0001);
    chk("R11 idle miso at end", {15'd0, spi_miso}, 16'h0000);

    summary();
  end
endmodule